// File: doc/BRIEF.md
# Extended Display Window Comparator

This block decides, on every clock, whether the raster beam lies inside a programmable rectangular display window. Software loads an upper-left corner word and a lower-right corner word. Each word holds the low eight bits of a vertical position and the low eight bits of a horizontal position. A third word, the extension word, supplies the most significant bits of both corners. The beam position arrives as an 11-bit line counter and a 9-bit pixel counter. The block produces one window-active flag.

Two ways of forming the upper bits exist side by side. In inferred mode, the missing bits are derived from fixed rules. These rules keep the upper-left corner near the top left of the screen and the lower-right corner toward the bottom right. In extended mode, the bits come from the extension word, so either corner can sit anywhere. The order of writes selects the mode. Writing the extension word selects extended mode. A later write to either corner word falls back to inferred mode until the extension word is written again.

The window is tracked as two open/closed latches, one per axis. Each latch opens when its counter equals the corner's start value and closes when the counter equals the stop value. The output is the AND of the two latches.

Top module: `dispWindow`

## Requirements
- R1: After reset the output is low, the mode is inferred, and all three words are zero. The window then spans vertical 0x000 to 0x100 and horizontal 0x000 to 0x100.
- R2: In a corner word, bits 15:8 carry vertical bits 7:0 and bits 7:0 carry horizontal bits 7:0.
- R3: In inferred mode, the start corner takes horizontal bit 8 = 0 and vertical bits 10:8 = 0.
- R4: In inferred mode, the stop corner takes horizontal bit 8 = 1, vertical bit 8 = inverse of vertical bit 7, and vertical bits 10:9 = 0.
- R5: In the extension word, bit 13 is stop horizontal bit 8, bits 10:8 are stop vertical bits 10:8, bit 5 is start horizontal bit 8, and bits 2:0 are start vertical bits 10:8. All other bits are ignored.
- R6: A write of the extension word puts both corners into extended mode from the next clock.
- R7: A write of either corner word without an extension write in the same cycle returns both corners to inferred mode from the next clock. When both happen in the same cycle, the extension write wins.
- R8: The vertical latch opens the clock after the line counter equals the start line. It closes the clock after the line counter equals the stop line. When both match, closing wins.
- R9: The horizontal latch follows the same rule using the pixel counter and the horizontal start and stop values.
- R10: The output is the AND of the two latches. It therefore reflects the beam position one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrStart | input | 1 | Write strobe for the start corner word |
| wrStop | input | 1 | Write strobe for the stop corner word |
| wrHigh | input | 1 | Write strobe for the extension word |
| wrData | input | 16 | Write data shared by all three words |
| vPos | input | 11 | Beam line counter |
| hPos | input | 9 | Beam pixel counter |
| winActive | output | 1 | Beam is inside the window (one clock latency) |

## Verification
The assertions assume that the beam counters are clean, synchronous values. Register writes are expected to occur on separate clock edges from any latch decision that the checks reason about. The checks also assume the corner values are stable within the cycle in which a match is evaluated.

The bench drives the beam and all write strobes on the falling edge and holds them for a full cycle. It issues one register write per cycle. It places the beam only on chosen positions, so every opening and closing happens at a known edge.

// File: rtl/dispWindowPkg.sv
package dispWindowPkg;
  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic loadStart;
    logic loadStop;
    logic loadHigh;
    logic explicitMode;
  } winStrobes_t;
endpackage

// File: rtl/winCtrl.sv
module winCtrl
  import dispWindowPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStart,
  input  logic        wrStop,
  input  logic        wrHigh,
  output winStrobes_t strobes
);
  logic explicitQ;

  // Extension write wins over a simultaneous corner write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  explicitQ <= 1'b0;
    else if (wrHigh)            explicitQ <= 1'b1;
    else if (wrStart || wrStop) explicitQ <= 1'b0;
  end

  always_comb begin
    strobes.loadStart    = wrStart;
    strobes.loadStop     = wrStop;
    strobes.loadHigh     = wrHigh;
    strobes.explicitMode = explicitQ;
  end

  a_r6_high_selects_explicit: assert property (@(posedge clk) disable iff (!rstN)
    wrHigh |=> strobes.explicitMode);

  a_r7_corner_write_reverts: assert property (@(posedge clk) disable iff (!rstN)
    ((wrStart || wrStop) && !wrHigh) |=> !strobes.explicitMode);
endmodule

// File: rtl/winDatapath.sv
module winDatapath
  import dispWindowPkg::*;
#(
  parameter int VPOS_W = 11,
  parameter int HPOS_W = 9,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobes_t       strobes,
  input  logic [WORD_W-1:0] wrData,
  input  logic [VPOS_W-1:0] vPos,
  input  logic [HPOS_W-1:0] hPos,
  output logic              winActive
);
  localparam int LOW_W    = WORD_W / 2;
  localparam int VEXT_W   = VPOS_W - LOW_W;
  localparam int STOP_OFS = 8;
  localparam int HBIT     = 5;

  logic [WORD_W-1:0] startReg, stopReg, highReg;
  logic [VPOS_W-1:0] vStartEff, vStopEff;
  logic [HPOS_W-1:0] hStartEff, hStopEff;
  logic              vOpen, hOpen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startReg <= '0;
      stopReg  <= '0;
      highReg  <= '0;
    end else begin
      if (strobes.loadStart) startReg <= wrData;
      if (strobes.loadStop)  stopReg  <= wrData;
      if (strobes.loadHigh)  highReg  <= wrData;
    end
  end

  // Effective corner positions
  always_comb begin
    if (strobes.explicitMode) begin
      vStartEff = {highReg[VEXT_W-1:0], startReg[WORD_W-1:LOW_W]};
      hStartEff = {highReg[HBIT], startReg[LOW_W-1:0]};
      vStopEff  = {highReg[STOP_OFS+VEXT_W-1:STOP_OFS], stopReg[WORD_W-1:LOW_W]};
      hStopEff  = {highReg[STOP_OFS+HBIT], stopReg[LOW_W-1:0]};
    end else begin
      vStartEff = {{VEXT_W{1'b0}}, startReg[WORD_W-1:LOW_W]};
      hStartEff = {1'b0, startReg[LOW_W-1:0]};
      vStopEff  = {{(VEXT_W-1){1'b0}}, ~stopReg[WORD_W-1], stopReg[WORD_W-1:LOW_W]};
      hStopEff  = {1'b1, stopReg[LOW_W-1:0]};
    end
  end

  // Per-axis latches: a stop match has priority over a start match
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vOpen <= 1'b0;
      hOpen <= 1'b0;
    end else begin
      if (vPos == vStopEff)       vOpen <= 1'b0;
      else if (vPos == vStartEff) vOpen <= 1'b1;
      if (hPos == hStopEff)       hOpen <= 1'b0;
      else if (hPos == hStartEff) hOpen <= 1'b1;
    end
  end

  assign winActive = vOpen & hOpen;

  a_r8_stop_line_closes: assert property (@(posedge clk) disable iff (!rstN)
    (vPos == vStopEff) |=> !winActive);

  a_r9_stop_pixel_closes: assert property (@(posedge clk) disable iff (!rstN)
    (hPos == hStopEff) |=> !winActive);

  a_r8_open_needs_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vOpen) |-> ($past(vPos) == $past(vStartEff)));

  a_r3_inferred_start_low: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.explicitMode && vPos[VPOS_W-1:LOW_W] != '0 && !vOpen) |=> !vOpen);
endmodule

// File: rtl/dispWindow.sv
module dispWindow
  import dispWindowPkg::*;
#(
  parameter int VPOS_W = 11,
  parameter int HPOS_W = 9,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrStart,
  input  logic              wrStop,
  input  logic              wrHigh,
  input  logic [WORD_W-1:0] wrData,
  input  logic [VPOS_W-1:0] vPos,
  input  logic [HPOS_W-1:0] hPos,
  output logic              winActive
);
  winStrobes_t strobes;

  winCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrStop(wrStop),
    .wrHigh(wrHigh), .strobes(strobes)
  );

  winDatapath #(.VPOS_W(VPOS_W), .HPOS_W(HPOS_W), .WORD_W(WORD_W)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrData(wrData),
    .vPos(vPos), .hPos(hPos), .winActive(winActive)
  );
endmodule

// File: tb/test_dispWindow.sv
module test_dispWindow;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStart = 1'b0, wrStop = 1'b0, wrHigh = 1'b0;
  logic [15:0] wrData = '0;
  logic [10:0] vPos = '0;
  logic [8:0]  hPos = '0;
  logic        winActive;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  dispWindow i_dispWindow (
    .clk(clk), .rstN(rstN), .wrStart(wrStart), .wrStop(wrStop),
    .wrHigh(wrHigh), .wrData(wrData), .vPos(vPos), .hPos(hPos),
    .winActive(winActive)
  );

  task automatic check(input logic exp, input string req);
    checks++;
    if (winActive !== exp) begin
      errors++;
      $display("FAIL %s: winActive=%0b expected %0b", req, winActive, exp);
    end
  endtask

  // which: 0 start, 1 stop, 2 extension
  task automatic writeReg(input int which, input logic [15:0] d);
    @(negedge clk);
    wrData  = d;
    wrStart = (which == 0);
    wrStop  = (which == 1);
    wrHigh  = (which == 2);
    @(negedge clk);
    wrStart = 1'b0; wrStop = 1'b0; wrHigh = 1'b0;
  endtask

  task automatic beam(input logic [10:0] v, input logic [8:0] h);
    @(negedge clk);
    vPos = v; hPos = h;
    @(posedge clk);
    #1;
  endtask

  task automatic testReset();
    check(1'b0, "R1 reset low");
    beam(11'h000, 9'h000); check(1'b1, "R1 zero words open at 0,0");
    beam(11'h100, 9'h100); check(1'b0, "R1 zero words close at 0x100");
  endtask

  task automatic testInferred();
    writeReg(0, 16'h2C81);
    writeReg(1, 16'hF4C1);
    beam(11'h02C, 9'h000); check(1'b0, "R10 vertical only is not active");
    beam(11'h02C, 9'h081); check(1'b1, "R2 R3 start corner opens");
    beam(11'h02C, 9'h0C1); check(1'b1, "R4 stop H8 forced one");
    beam(11'h02C, 9'h1C1); check(1'b0, "R9 horizontal stop closes");
    beam(11'h02D, 9'h081); check(1'b1, "R9 horizontal reopens next line");
    beam(11'h0F4, 9'h081); check(1'b0, "R8 vertical stop closes");
    beam(11'h12C, 9'h081); check(1'b0, "R3 start V8 forced zero");
  endtask

  task automatic testStopInvert();
    writeReg(0, 16'h1010);
    writeReg(1, 16'h2040);
    beam(11'h010, 9'h010); check(1'b1, "R2 opens at 0x10,0x10");
    beam(11'h020, 9'h010); check(1'b1, "R4 stop V8 is inverse of V7");
    beam(11'h120, 9'h010); check(1'b0, "R4 stop line 0x120 closes");
    beam(11'h000, 9'h140); check(1'b0, "R4 stop pixel 0x140 closes");
  endtask

  task automatic testExplicit();
    writeReg(0, 16'h1020);
    writeReg(1, 16'h3050);
    writeReg(2, 16'h8221);
    beam(11'h010, 9'h020); check(1'b0, "R6 inferred start not used");
    beam(11'h110, 9'h120); check(1'b1, "R5 start upper bits applied");
    beam(11'h110, 9'h050); check(1'b0, "R5 stop H8 zero closes");
    beam(11'h130, 9'h120); check(1'b1, "R5 stop vertical upper bits not inferred");
    beam(11'h230, 9'h120); check(1'b0, "R5 stop line 0x230 closes");
  endtask

  task automatic testRevert();
    writeReg(0, 16'h1020);
    beam(11'h110, 9'h020); check(1'b0, "R7 extension start dropped");
    beam(11'h010, 9'h020); check(1'b1, "R7 inferred start used");
    beam(11'h230, 9'h020); check(1'b1, "R7 extension stop dropped");
    beam(11'h130, 9'h020); check(1'b0, "R7 inferred stop closes");
    beam(11'h000, 9'h150); check(1'b0, "R7 inferred horizontal stop");
  endtask

  task automatic testPriority();
    writeReg(0, 16'h4040);
    writeReg(1, 16'h4040);
    writeReg(2, 16'h0000);
    beam(11'h040, 9'h040); check(1'b0, "R8 R9 stop wins on equal match");
    beam(11'h041, 9'h041); check(1'b0, "R8 stays closed");
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(1'b0, "R1 output low in reset");
    rstN = 1'b1;
    testReset();
    testInferred();
    testStopInvert();
    testExplicit();
    testRevert();
    testPriority();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule